// File: doc/BRIEF.md
# HDLC Interrupt Status and Mask

This block gathers single-cycle event pulses from an HDLC transmitter and receiver into an 8-bit latched interrupt status register. It qualifies that register with an 8-bit enable mask and drives an active-low interrupt request toward a microprocessor. A masked event is still recorded in the status register, so software can poll for it. Only the interrupt request line stays quiet for a masked event.

Status bit 2 is shared between two events. A control input selects whether the bit records transmit FIFO underrun or frame abort, and the event that is not selected is dropped. The microprocessor reaches both registers through a simple one-address-bit port. Reading the status register clears every bit it has returned, but an event that arrives in the same cycle as the read is kept. Writes go only to the mask; a write to the status address is discarded.

Top module: `hdlc_irq_ctrl`

## Requirements
- R1: After reset the status register and the mask are both all zeros and irq_n_o is high.
- R2: An event pulse on evt_i[i] (i other than 2) sets status bit i at the next clock edge. The bit stays set until the status register is read.
- R3: An event whose mask bit is 0 still sets its status bit, but it does not drive irq_n_o low.
- R4: irq_n_o is low exactly when some status bit and the mask bit in the same position are both 1. An enabled event therefore pulls irq_n_o low in the cycle after its pulse.
- R5: When sel_under_i is 1, status bit 2 is set by tx_under_i. When sel_under_i is 0, status bit 2 is set by frame_abort_i. The unselected source and evt_i[2] have no effect.
- R6: With reg_sel_i = 0, reg_rdata_o shows the status register. Asserting reg_rd_i clears all status bits at the next edge, except bits whose event arrives in that same cycle.
- R7: A write with reg_sel_i = 1 loads the mask at the next edge, and reg_rdata_o shows the mask while reg_sel_i = 1. A status bit that is already pending asserts irq_n_o in the cycle after it is unmasked.
- R8: A write with reg_sel_i = 0 changes neither the status register nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event pulses, one per status bit; bit 2 is unused |
| tx_under_i | input | 1 | Transmit FIFO underrun pulse |
| frame_abort_i | input | 1 | Frame abort pulse |
| sel_under_i | input | 1 | Source select for status bit 2 (1 = underrun, 0 = frame abort) |
| reg_sel_i | input | 1 | Register select: 0 = status, 1 = mask |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status when reg_sel_i = 0) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Every result is due one clock edge after its stimulus. An event pulse, a status read-clear and a mask write each take effect at the edge that samples them. Read data and irq_n_o follow the registers combinationally, so they are valid as soon as that edge has passed. The bench drives inputs 1 ns after a rising edge and checks outputs 1 ns after the following edge. It also checks some outputs before that edge, to confirm that nothing changes early. The sweeps cover every single-bit event under all 256 masks, and every event pattern paired with a derived mask.

// File: rtl/hdlc_irq_ctrl.sv
module hdlc_irq_ctrl #(
  parameter int W      = 8,
  parameter int SHARED = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         tx_under_i,
  input  logic         frame_abort_i,
  input  logic         sel_under_i,
  input  logic         reg_sel_i,
  input  logic         reg_wr_i,
  input  logic         reg_rd_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         irq_n_o
);

  logic [W-1:0] status_q, mask_q, evt_eff;
  logic         rd_stat, wr_mask;

  always_comb begin
    evt_eff         = evt_i;
    evt_eff[SHARED] = sel_under_i ? tx_under_i : frame_abort_i;
  end

  assign rd_stat = reg_rd_i & ~reg_sel_i;
  assign wr_mask = reg_wr_i &  reg_sel_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status_q <= '0;
    else        status_q <= (rd_stat ? '0 : status_q) | evt_eff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata_i;

  assign reg_rdata_o = reg_sel_i ? mask_q : status_q;
  assign irq_n_o     = ~|(status_q & mask_q);

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> (status_q & $past(status_q)) == $past(status_q));

  // R6
  rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> status_q == $past(evt_eff));

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_eff & mask_q)) && !wr_mask |=> !irq_n_o);

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask_q == $past(reg_wdata_i));

  // R5
  shared_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_under_i && tx_under_i) || (!sel_under_i && frame_abort_i) |=> status_q[SHARED]);

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));

endmodule

// File: tb/test_hdlc_irq_ctrl.sv
`timescale 1ns/1ps
module test_hdlc_irq_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [7:0] evt = 0, wdata = 0;
  logic       under = 0, fa = 0, sel_u = 1, rsel = 0, wr = 0, rd = 0;
  logic [7:0] rdata;
  logic       irq_n;
  int checks = 0, fails = 0;

  hdlc_irq_ctrl i_hdlc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .tx_under_i(under),
    .frame_abort_i(fa), .sel_under_i(sel_u), .reg_sel_i(rsel),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_n_o(irq_n));

  always #2 clk = ~clk;

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input int got, input int exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic set_mask(input logic [7:0] m);
    rsel = 1; wr = 1; wdata = m; tick; wr = 0; rsel = 0;
  endtask

  task automatic pulse(input logic [7:0] e, input logic u, input logic a);
    evt = e; under = u; fa = a; tick; evt = 0; under = 0; fa = 0;
  endtask

  task automatic read_stat(output logic [7:0] v);
    rsel = 0; rd = 1; #1; v = rdata; tick; rd = 0;
  endtask

  task automatic peek_stat(output logic [7:0] v);
    rsel = 0; #1; v = rdata;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    #5 rst_n = 1; tick;
    // R1
    peek_stat(v); chk(v, 0, "R1 status");
    rsel = 1; #1; chk(rdata, 0, "R1 mask"); rsel = 0;
    chk(irq_n, 1, "R1 irq_n");

    // R2 R3 R4: single-bit events under every mask
    for (int m = 0; m < 256; m++) begin
      set_mask(m[7:0]);
      for (int b = 0; b < 8; b++) begin
        if (b == 2) pulse(8'h00, 1'b1, 1'b0);
        else        pulse(8'(1 << b), 1'b0, 1'b0);
        pulse(8'h00, 1'b0, 1'b0);
        peek_stat(v);
        chk(v, 1 << b, "R2 status bit latched and held");
        chk(irq_n, ((m >> b) & 1) ? 0 : 1, "R3 R4 irq_n vs mask");
        read_stat(v);
      end
    end

    // R4 R6: every event pattern with a derived mask
    for (int e = 0; e < 256; e++) begin
      logic [7:0] m;
      m = e[7:0] ^ 8'hA5;
      set_mask(m);
      pulse(e[7:0], e[2], 1'b0);
      chk(irq_n, ((e & m) != 0) ? 0 : 1, "R4 irq_n pattern");
      read_stat(v);
      chk(v, e, "R6 read value");
      peek_stat(v);
      chk(v, 0, "R6 cleared after read");
    end

    // R5 source select
    set_mask(8'h04);
    sel_u = 1; pulse(8'h04, 1'b0, 1'b1); peek_stat(v);
    chk(v, 0, "R5 abort and evt_i[2] ignored when underrun selected");
    chk(irq_n, 1, "R5 no irq from unselected");
    pulse(8'h00, 1'b1, 1'b0); peek_stat(v);
    chk(v, 8'h04, "R5 underrun sets bit 2"); read_stat(v);
    sel_u = 0; pulse(8'h04, 1'b1, 1'b0); peek_stat(v);
    chk(v, 0, "R5 underrun ignored when abort selected");
    pulse(8'h00, 1'b0, 1'b1); peek_stat(v);
    chk(v, 8'h04, "R5 abort sets bit 2"); chk(irq_n, 0, "R5 irq from abort");
    read_stat(v); sel_u = 1;

    // R6 event during read is kept
    set_mask(8'h00);
    pulse(8'h81, 1'b0, 1'b0);
    rsel = 0; rd = 1; evt = 8'h20; #1;
    chk(rdata, 8'h81, "R6 read data before clear");
    tick; rd = 0; evt = 0;
    peek_stat(v); chk(v, 8'h20, "R6 same-cycle event kept");

    // R7 unmasking a pending bit
    chk(irq_n, 1, "R7 pending bit masked");
    rsel = 1; wr = 1; wdata = 8'h20; #1;
    chk(irq_n, 1, "R7 no effect before edge");
    tick; wr = 0;
    chk(rdata, 8'h20, "R7 mask read back");
    chk(irq_n, 0, "R7 irq after unmask");
    rsel = 0;

    // R8 status-address write ignored
    wr = 1; rsel = 0; wdata = 8'hFF; tick; wr = 0;
    peek_stat(v); chk(v, 8'h20, "R8 status unchanged");
    rsel = 1; #1; chk(rdata, 8'h20, "R8 mask unchanged"); rsel = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule